// File: doc/BRIEF.md
# Well-Known Region Access Checker

This block is the fast path of an address-protection unit. It holds a small set of register-defined regions that cover most of a program's memory traffic, and it tests every access against them before the slower protection lookup buffer is asked. The current protection domain contributes three regions: code, read-only constants and writable data. The running thread contributes two more: thread-local storage and its stack. An access that lands inside one of these regions, and that the region's right allows, is granted in the same cycle, and the buffer lookup is suppressed. Any other access raises a forward request so that the buffer (outside this block) decides.

The stack region is not a fixed pair of bounds. Its low edge follows the stack pointer, so frames that have been popped can no longer be reached. A reserve operation can extend the low edge below the stack pointer to build an outgoing argument area. On a call, that area is handed to the callee as a separate incoming-argument region. The block also marks freshly pushed stack words that have not been written since their allocation, so that reads of them can be served as zero.

A load port fills any region from saved state. A combinational save port returns any region's bounds so that state can be spilled on a domain or thread switch.

Top module: `wkreg_check`

## Requirements
- R1: After reset every region is empty (both bounds zero). Every valid access then has `acc_fwd`=1 and `acc_hit`=0, and the save port returns zero bounds.
- R2: Region 0 (code) grants only fetches (`acc_kind`=0). A read (1) or write (2) that falls only inside the code region is forwarded.
- R3: Region 1 (constants) grants only reads. A write that falls only inside it is forwarded.
- R4: Region 2 (data) and region 3 (thread-local storage) grant reads and writes, and never grant fetches. `acc_kind`=3 is granted by no region.
- R5: Each region covers the addresses from its low bound up to, but not including, its high bound.
- R6: Loading region 4 sets the stack pointer to `ld_lo` and the stack base to `ld_hi`. The stack region is [low edge, base), where the low edge equals the stack pointer unless an argument reserve is active. A write on `sp_we` moves the stack pointer, and the region moves with it.
- R7: `args_en` sets the low edge to the stack pointer minus `args_size`, saturating at zero. This adds the outgoing area to the stack region. A later `sp_we` returns the low edge to the new stack pointer, which cancels the reserve. `sp_we` takes priority over `args_en` in the same cycle.
- R8: `call_en` copies the current low edge into the low bound of region 5 (incoming arguments) and the current stack pointer into its high bound. Region 5 grants reads and writes. Neither a later stack reload nor a later stack pointer move changes region 5.
- R9: When regions overlap, `acc_rgn` reports the granting region with the lowest index.
- R10: `acc_hit` and `acc_fwd` are combinational in the access cycle: `acc_fwd` = `acc_valid` and not `acc_hit`. Both are 0 when `acc_valid` is 0.
- R11: A granted read at an address in [stack pointer, fresh top) raises `zero_fill`. A stack load sets fresh top to the stack pointer. A stack pointer move sets fresh top to the larger of the old fresh top and the new stack pointer. A write at an address in [stack pointer, fresh top) lowers fresh top to that address.
- R12: The save port returns the bounds selected by `sv_sel`: regions 0 to 3 return their bounds, 4 returns {stack pointer, base}, 5 returns the region-5 bounds, and 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load the region chosen by ld_sel |
| ld_sel | input | 3 | Region index to load (0 code, 1 const, 2 data, 3 TLS, 4 stack, 5 incoming args) |
| ld_lo | input | AW | Low bound (stack pointer for region 4) |
| ld_hi | input | AW | High bound (stack base for region 4) |
| sp_we | input | 1 | Move the stack pointer |
| sp_val | input | AW | New stack pointer |
| args_en | input | 1 | Reserve an outgoing argument area below the stack pointer |
| args_size | input | ARGW | Size of the reserve in address units |
| call_en | input | 1 | Call event: hand the outgoing area to region 5 |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| acc_addr | input | AW | Access address |
| acc_hit | output | 1 | Access granted by a region |
| acc_fwd | output | 1 | Access must go to the protection buffer |
| acc_rgn | output | 3 | Index of the granting region |
| zero_fill | output | 1 | Granted read of an unwritten fresh stack word |
| sv_sel | input | 3 | Region index for the save port |
| sv_lo | output | AW | Saved low bound |
| sv_hi | output | AW | Saved high bound |

## Verification
Fetches, reads and writes are sent to each region at its first word, its last word and one past its end. This separates wrong rights from wrong boundary comparisons. The stack is driven through a sequence of pointer moves, reserves and calls, with a reload into a second stack area. This tells a low edge that follows the pointer apart from one that keeps its old reserve, and shows whether region 5 keeps the values it took at the call. Overlapping data and thread-local regions check the priority order. Writes inside a fresh frame, followed by reads above and below the write, check the zero marking. A pointer move past the fresh top checks that it is clamped.

// File: rtl/wkreg_pkg.sv
package wkreg_pkg;

   localparam int NUM_RGN   = 6;
   localparam int NUM_TURF  = 4;
   localparam int RGN_W     = 3;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_NONE  = 2'd3
   } acc_kind_e;

   typedef enum logic [RGN_W-1:0] {
      RG_CODE  = 3'd0,
      RG_CONST = 3'd1,
      RG_DATA  = 3'd2,
      RG_TLS   = 3'd3,
      RG_STACK = 3'd4,
      RG_ARGS  = 3'd5
   } rgn_e;

   typedef struct packed {
      logic x;
      logic r;
      logic w;
   } rights_t;

   // rights carried by each well-known region
   function automatic rights_t rgn_rights(input int idx);
      rights_t rt;
      case (idx)
         0:       rt = '{x: 1'b1, r: 1'b0, w: 1'b0};
         1:       rt = '{x: 1'b0, r: 1'b1, w: 1'b0};
         default: rt = '{x: 1'b0, r: 1'b1, w: 1'b1};
      endcase
      return rt;
   endfunction

endpackage

// File: rtl/wkreg_range_hit.sv
module wkreg_range_hit
   import wkreg_pkg::*;
#(
   parameter int      AW     = 32,
   parameter rights_t RIGHTS = '{x: 1'b0, r: 1'b1, w: 1'b1}
) (
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   input  logic [AW-1:0] addr,
   input  logic [1:0]    kind,
   output logic          hit
);
   logic in_rng;
   logic allowed;

   assign in_rng = (addr >= lo) && (addr < hi);

   always_comb begin
      case (acc_kind_e'(kind))
         ACC_FETCH: allowed = RIGHTS.x;
         ACC_READ:  allowed = RIGHTS.r;
         ACC_WRITE: allowed = RIGHTS.w;
         default:   allowed = 1'b0;
      endcase
   end

   assign hit = in_rng & allowed;
endmodule

// File: rtl/wkreg_turf_bank.sv
module wkreg_turf_bank
   import wkreg_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ld_en,
   input  logic [RGN_W-1:0]             ld_sel,
   input  logic [AW-1:0]                ld_lo,
   input  logic [AW-1:0]                ld_hi,
   output logic [NUM_TURF-1:0][AW-1:0]  lo_o,
   output logic [NUM_TURF-1:0][AW-1:0]  hi_o
);
   for (genvar g = 0; g < NUM_TURF; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_o[g] <= '0;
            hi_o[g] <= '0;
         end else if (ld_en && (ld_sel == RGN_W'(g))) begin
            lo_o[g] <= ld_lo;
            hi_o[g] <= ld_hi;
         end
      end
   end
endmodule

// File: rtl/wkreg_stack_ctl.sv
module wkreg_stack_ctl
   import wkreg_pkg::*;
#(
   parameter int AW         = 32,
   parameter int ARGW       = 16,
   parameter bit ZERO_TRACK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [RGN_W-1:0] ld_sel,
   input  logic [AW-1:0]    ld_lo,
   input  logic [AW-1:0]    ld_hi,
   input  logic             sp_we,
   input  logic [AW-1:0]    sp_val,
   input  logic             args_en,
   input  logic [ARGW-1:0]  args_size,
   input  logic             call_en,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   output logic [AW-1:0]    sp_o,
   output logic [AW-1:0]    edge_o,
   output logic [AW-1:0]    base_o,
   output logic [AW-1:0]    arg_lo_o,
   output logic [AW-1:0]    arg_hi_o,
   output logic [AW-1:0]    fresh_o
);
   logic            ld_stk;
   logic            ld_arg;
   logic [AW-1:0]   args_ext;
   logic [AW-1:0]   reserve_edge;

   assign ld_stk       = ld_en && (ld_sel == RG_STACK);
   assign ld_arg       = ld_en && (ld_sel == RG_ARGS);
   assign args_ext     = AW'(args_size);
   assign reserve_edge = (args_ext > sp_o) ? '0 : (sp_o - args_ext);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_o   <= '0;
         edge_o <= '0;
         base_o <= '0;
      end else if (ld_stk) begin
         sp_o   <= ld_lo;
         edge_o <= ld_lo;
         base_o <= ld_hi;
      end else if (sp_we) begin
         sp_o   <= sp_val;
         edge_o <= sp_val;
      end else if (args_en) begin
         edge_o <= reserve_edge;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arg_lo_o <= '0;
         arg_hi_o <= '0;
      end else if (ld_arg) begin
         arg_lo_o <= ld_lo;
         arg_hi_o <= ld_hi;
      end else if (call_en) begin
         arg_lo_o <= edge_o;
         arg_hi_o <= sp_o;
      end
   end

   if (ZERO_TRACK) begin : g_fresh
      logic [AW-1:0] fresh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fresh_q <= '0;
         end else if (ld_stk) begin
            fresh_q <= ld_lo;
         end else if (sp_we) begin
            fresh_q <= (sp_val > fresh_q) ? sp_val : fresh_q;
         end else if (wr_en && (wr_addr >= sp_o) && (wr_addr < fresh_q)) begin
            fresh_q <= wr_addr;
         end
      end
      assign fresh_o = fresh_q;
   end else begin : g_nofresh
      assign fresh_o = sp_o;
   end
endmodule

// File: rtl/wkreg_check.sv
module wkreg_check
   import wkreg_pkg::*;
#(
   parameter int AW         = 32,
   parameter int ARGW       = 16,
   parameter bit ZERO_TRACK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [2:0]       ld_sel,
   input  logic [AW-1:0]    ld_lo,
   input  logic [AW-1:0]    ld_hi,
   input  logic             sp_we,
   input  logic [AW-1:0]    sp_val,
   input  logic             args_en,
   input  logic [ARGW-1:0]  args_size,
   input  logic             call_en,
   input  logic             acc_valid,
   input  logic [1:0]       acc_kind,
   input  logic [AW-1:0]    acc_addr,
   output logic             acc_hit,
   output logic             acc_fwd,
   output logic [2:0]       acc_rgn,
   output logic             zero_fill,
   input  logic [2:0]       sv_sel,
   output logic [AW-1:0]    sv_lo,
   output logic [AW-1:0]    sv_hi
);
   if (AW < 8) begin : g_bad_aw
      $error("wkreg_check: AW must be at least 8");
   end
   if (ARGW < 1 || ARGW > AW) begin : g_bad_argw
      $error("wkreg_check: ARGW must lie in 1..AW");
   end

   logic [NUM_TURF-1:0][AW-1:0] turf_lo;
   logic [NUM_TURF-1:0][AW-1:0] turf_hi;
   logic [AW-1:0] stk_sp, stk_lo, stk_hi, arg_lo, arg_hi, fresh_top;
   logic [AW-1:0] rg_lo [NUM_RGN];
   logic [AW-1:0] rg_hi [NUM_RGN];
   logic [NUM_RGN-1:0] rhit;
   logic wr_en;

   assign wr_en = acc_valid && (acc_kind == ACC_WRITE);

   wkreg_turf_bank #(.AW(AW)) u_bank (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .lo_o(turf_lo), .hi_o(turf_hi)
   );

   wkreg_stack_ctl #(.AW(AW), .ARGW(ARGW), .ZERO_TRACK(ZERO_TRACK)) u_stack (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .sp_we(sp_we), .sp_val(sp_val),
      .args_en(args_en), .args_size(args_size), .call_en(call_en),
      .wr_en(wr_en), .wr_addr(acc_addr),
      .sp_o(stk_sp), .edge_o(stk_lo), .base_o(stk_hi),
      .arg_lo_o(arg_lo), .arg_hi_o(arg_hi), .fresh_o(fresh_top)
   );

   for (genvar t = 0; t < NUM_TURF; t++) begin : g_map
      assign rg_lo[t] = turf_lo[t];
      assign rg_hi[t] = turf_hi[t];
   end
   assign rg_lo[RG_STACK] = stk_lo;
   assign rg_hi[RG_STACK] = stk_hi;
   assign rg_lo[RG_ARGS]  = arg_lo;
   assign rg_hi[RG_ARGS]  = arg_hi;

   for (genvar i = 0; i < NUM_RGN; i++) begin : g_cmp
      wkreg_range_hit #(.AW(AW), .RIGHTS(rgn_rights(i))) u_cmp (
         .lo(rg_lo[i]), .hi(rg_hi[i]), .addr(acc_addr),
         .kind(acc_kind), .hit(rhit[i])
      );
   end

   // lowest index wins
   always_comb begin
      acc_hit = 1'b0;
      acc_rgn = '0;
      for (int i = NUM_RGN - 1; i >= 0; i--) begin
         if (acc_valid && rhit[i]) begin
            acc_hit = 1'b1;
            acc_rgn = 3'(i);
         end
      end
   end

   assign acc_fwd   = acc_valid && !acc_hit;
   assign zero_fill = acc_hit && (acc_kind == ACC_READ) &&
                      (acc_addr >= stk_sp) && (acc_addr < fresh_top);

   always_comb begin
      case (sv_sel)
         3'd0, 3'd1, 3'd2, 3'd3: begin
            sv_lo = turf_lo[sv_sel[1:0]];
            sv_hi = turf_hi[sv_sel[1:0]];
         end
         3'd4: begin sv_lo = stk_sp; sv_hi = stk_hi; end
         3'd5: begin sv_lo = arg_lo; sv_hi = arg_hi; end
         default: begin sv_lo = '0; sv_hi = '0; end
      endcase
   end
endmodule

// File: rtl/wkreg_check_sva.sv
module wkreg_check_sva #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_en,
   input logic [2:0]    ld_sel,
   input logic          sp_we,
   input logic          call_en,
   input logic          acc_valid,
   input logic [1:0]    acc_kind,
   input logic [AW-1:0] acc_addr,
   input logic          acc_hit,
   input logic          acc_fwd,
   input logic [2:0]    acc_rgn,
   input logic          zero_fill,
   input logic [AW-1:0] stk_sp,
   input logic [AW-1:0] stk_lo,
   input logic [AW-1:0] stk_hi,
   input logic [AW-1:0] arg_lo,
   input logic [AW-1:0] arg_hi
);
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!acc_hit && !acc_fwd));

   p_fetch_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && acc_kind == 2'd0) |-> (acc_rgn == 3'd0));

   p_write_rw_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && acc_kind == 2'd2) |-> (acc_rgn >= 3'd2));

   p_stack_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && acc_rgn == 3'd4) |-> (acc_addr >= stk_lo && acc_addr < stk_hi));

   p_edge_below_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stk_lo <= stk_sp);

   p_sp_cancels_reserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_we && !(ld_en && ld_sel == 3'd4)) |=> (stk_lo == stk_sp));

   p_call_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (call_en && !(ld_en && ld_sel == 3'd5)) |=>
         (arg_lo == $past(stk_lo) && arg_hi == $past(stk_sp)));

   p_zero_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      zero_fill |-> (acc_hit && acc_kind == 2'd1));
endmodule

bind wkreg_check wkreg_check_sva #(.AW(AW)) u_sva (
   .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
   .sp_we(sp_we), .call_en(call_en), .acc_valid(acc_valid),
   .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_hit(acc_hit),
   .acc_fwd(acc_fwd), .acc_rgn(acc_rgn), .zero_fill(zero_fill),
   .stk_sp(stk_sp), .stk_lo(stk_lo), .stk_hi(stk_hi),
   .arg_lo(arg_lo), .arg_hi(arg_hi)
);

// File: tb/tb_wkreg_check.sv
module tb_wkreg_check;
   localparam int AW    = 32;
   localparam int ARGW  = 16;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_en = 0, sp_we = 0, args_en = 0, call_en = 0, acc_valid = 0;
   logic [2:0] ld_sel = '0, sv_sel = '0;
   logic [AW-1:0] ld_lo = '0, ld_hi = '0, sp_val = '0, acc_addr = '0;
   logic [ARGW-1:0] args_size = '0;
   logic [1:0] acc_kind = '0;
   logic acc_hit, acc_fwd, zero_fill;
   logic [2:0] acc_rgn;
   logic [AW-1:0] sv_lo, sv_hi;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic       hit;
      logic       fwd;
      logic [2:0] rgn;
      logic       zero;
      logic [AW-1:0] addr;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_P/2) clk = ~clk;

   wkreg_check #(.AW(AW), .ARGW(ARGW), .ZERO_TRACK(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .sp_we(sp_we), .sp_val(sp_val),
      .args_en(args_en), .args_size(args_size), .call_en(call_en),
      .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
      .acc_hit(acc_hit), .acc_fwd(acc_fwd), .acc_rgn(acc_rgn),
      .zero_fill(zero_fill), .sv_sel(sv_sel), .sv_lo(sv_lo), .sv_hi(sv_hi)
   );

   task automatic idle();
      ld_en = 0; sp_we = 0; args_en = 0; call_en = 0; acc_valid = 0;
   endtask

   task automatic do_ld(input logic [2:0] sel, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
      @(negedge clk); idle(); ld_en = 1; ld_sel = sel; ld_lo = lo; ld_hi = hi;
   endtask

   task automatic do_sp(input logic [AW-1:0] v);
      @(negedge clk); idle(); sp_we = 1; sp_val = v;
   endtask

   task automatic do_args(input logic [ARGW-1:0] sz);
      @(negedge clk); idle(); args_en = 1; args_size = sz;
   endtask

   task automatic do_call();
      @(negedge clk); idle(); call_en = 1;
   endtask

   // driver: applies one access and queues what the requirements predict
   task automatic probe(input logic v, input logic [1:0] k, input logic [AW-1:0] a,
                        input logic eh, input logic ef, input logic [2:0] er,
                        input logic ez, input string tag);
      exp_t e;
      @(negedge clk); idle();
      acc_valid = v; acc_kind = k; acc_addr = a;
      e.hit = eh; e.fwd = ef; e.rgn = er; e.zero = ez; e.addr = a; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic chk_save(input logic [2:0] sel, input logic [AW-1:0] elo,
                           input logic [AW-1:0] ehi, input string tag);
      @(negedge clk); idle(); sv_sel = sel;
      #(CLK_P/4);
      checks++;
      if (sv_lo !== elo || sv_hi !== ehi) begin
         errors++;
         $display("FAIL %s save sel=%0d: got lo=%h hi=%h expected lo=%h hi=%h",
                  tag, sel, sv_lo, sv_hi, elo, ehi);
      end
   endtask

   // monitor: compares outputs against queued expectations
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (acc_hit !== e.hit || acc_fwd !== e.fwd || zero_fill !== e.zero ||
                (e.hit && acc_rgn !== e.rgn)) begin
               errors++;
               $display("FAIL %s addr=%h: got hit=%b fwd=%b rgn=%0d zero=%b expected hit=%b fwd=%b rgn=%0d zero=%b",
                        e.tag, e.addr, acc_hit, acc_fwd, acc_rgn, zero_fill,
                        e.hit, e.fwd, e.rgn, e.zero);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 reset state
      probe(1, 2'd1, 32'h100, 0, 1, 0, 0, "R1");
      probe(1, 2'd0, 32'h0,   0, 1, 0, 0, "R1");
      chk_save(3'd0, 0, 0, "R1");
      chk_save(3'd4, 0, 0, "R1");

      do_ld(3'd0, 32'h1000, 32'h2000);
      do_ld(3'd1, 32'h3000, 32'h3400);
      do_ld(3'd2, 32'h4000, 32'h5000);
      do_ld(3'd3, 32'h6000, 32'h6100);
      do_ld(3'd4, 32'h8000, 32'h9000);

      // R2 / R5 code region
      probe(1, 2'd0, 32'h1000, 1, 0, 0, 0, "R2");
      probe(1, 2'd0, 32'h1FFF, 1, 0, 0, 0, "R5");
      probe(1, 2'd0, 32'h2000, 0, 1, 0, 0, "R5");
      probe(1, 2'd0, 32'h0FFF, 0, 1, 0, 0, "R5");
      probe(1, 2'd1, 32'h1800, 0, 1, 0, 0, "R2");
      probe(1, 2'd2, 32'h1800, 0, 1, 0, 0, "R2");
      // R3 constants
      probe(1, 2'd1, 32'h3000, 1, 0, 1, 0, "R3");
      probe(1, 2'd2, 32'h3000, 0, 1, 0, 0, "R3");
      probe(1, 2'd0, 32'h33FF, 0, 1, 0, 0, "R3");
      // R4 data and TLS
      probe(1, 2'd2, 32'h4FFF, 1, 0, 2, 0, "R4");
      probe(1, 2'd1, 32'h4000, 1, 0, 2, 0, "R4");
      probe(1, 2'd0, 32'h4000, 0, 1, 0, 0, "R4");
      probe(1, 2'd1, 32'h6000, 1, 0, 3, 0, "R4");
      probe(1, 2'd2, 32'h60FF, 1, 0, 3, 0, "R4");
      probe(1, 2'd3, 32'h4000, 0, 1, 0, 0, "R4");
      // R10 idle
      probe(0, 2'd0, 32'h1000, 0, 0, 0, 0, "R10");
      // R6 stack
      probe(1, 2'd1, 32'h8000, 1, 0, 4, 0, "R6");
      probe(1, 2'd1, 32'h7FFF, 0, 1, 0, 0, "R6");
      probe(1, 2'd1, 32'h9000, 0, 1, 0, 0, "R6");
      chk_save(3'd4, 32'h8000, 32'h9000, "R12");
      do_sp(32'h7F00);
      probe(1, 2'd1, 32'h7F00, 1, 0, 4, 1, "R11");
      probe(1, 2'd1, 32'h8000, 1, 0, 4, 0, "R11");
      probe(1, 2'd1, 32'h7EFF, 0, 1, 0, 0, "R6");
      probe(1, 2'd2, 32'h7F80, 1, 0, 4, 0, "R6");
      probe(1, 2'd1, 32'h7F80, 1, 0, 4, 0, "R11");
      probe(1, 2'd1, 32'h7F7F, 1, 0, 4, 1, "R11");
      // R7 reserve
      do_args(16'h0040);
      probe(1, 2'd1, 32'h7EC0, 1, 0, 4, 0, "R7");
      probe(1, 2'd1, 32'h7EBF, 0, 1, 0, 0, "R7");
      chk_save(3'd4, 32'h7F00, 32'h9000, "R12");
      do_sp(32'h7F00);
      probe(1, 2'd1, 32'h7EC0, 0, 1, 0, 0, "R7");
      do_args(16'hFFFF);
      probe(1, 2'd2, 32'h7000, 1, 0, 4, 0, "R7");
      do_sp(32'h7F00);
      do_args(16'h0040);
      // R8 call handoff
      do_call();
      chk_save(3'd5, 32'h7EC0, 32'h7F00, "R8");
      do_ld(3'd4, 32'hA000, 32'hB000);
      do_sp(32'h9F00);
      probe(1, 2'd2, 32'h7EC0, 1, 0, 5, 0, "R8");
      probe(1, 2'd1, 32'h7EFF, 1, 0, 5, 0, "R8");
      probe(1, 2'd1, 32'h7F00, 0, 1, 0, 0, "R8");
      probe(1, 2'd0, 32'h7EC0, 0, 1, 0, 0, "R8");
      // R11 fresh tracking in new stack area
      probe(1, 2'd1, 32'h9F00, 1, 0, 4, 1, "R11");
      probe(1, 2'd2, 32'h9F10, 1, 0, 4, 0, "R11");
      do_sp(32'h9F80);
      probe(1, 2'd1, 32'h9F80, 1, 0, 4, 0, "R11");
      do_sp(32'h9F00);
      probe(1, 2'd1, 32'h9F40, 1, 0, 4, 1, "R11");
      probe(1, 2'd1, 32'h9F80, 1, 0, 4, 0, "R11");
      // R9 priority with overlapping data and TLS
      do_ld(3'd2, 32'h6000, 32'h7000);
      probe(1, 2'd1, 32'h6050, 1, 0, 2, 0, "R9");
      probe(1, 2'd1, 32'h6100, 1, 0, 2, 0, "R9");
      // R12 save port
      chk_save(3'd2, 32'h6000, 32'h7000, "R12");
      chk_save(3'd1, 32'h3000, 32'h3400, "R12");
      chk_save(3'd6, 0, 0, "R12");

      @(negedge clk); idle();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule